// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block turns a host request into one command frame for a register and DMA style SPI protocol and hands the frame out one byte at a time. The host supplies an opcode, a 24-bit address, a 32-bit write word, a 24-bit transfer size, a clockless flag and a CRC-disable mode bit, then pulses start. The encoder picks the byte layout from the opcode and latches the header. It then feeds each header byte through a bit-serial CRC7 engine and offers that byte on a valid/ready byte channel. The frame closes with the CRC7 byte unless the mode bit drops it.

The SPI shifter downstream consumes the bytes in order, most significant byte of every field first. Done pulses once the last byte has left. An opcode outside the supported set raises a one-cycle error, and no byte goes out.

Top module: `spi_cmd_framer`

## Requirements
- R1: After reset, tx_valid_o, busy_o, done_o and err_o are all 0.
- R2: Frame length including the CRC byte depends on the opcode. 0xC4 (internal read), 0xCA (single read), 0xC5 (terminate), 0xC6 (repeat) and 0xCF (reset) give 5 bytes. 0xC1 and 0xC2 (DMA write and read) give 7 bytes. 0xC3 (internal write), 0xC7 and 0xC8 (extended DMA write and read) give 8 bytes. 0xC9 (single write) gives 9 bytes. Byte 0 is always the opcode.
- R3: Single read, single write and all DMA opcodes send address bytes addr[23:16], addr[15:8], addr[7:0] after the opcode. DMA forms then send size[15:8], size[7:0]. Extended forms send size[23:16], size[15:8], size[7:0]. Single write sends wdata[31:24] down to wdata[7:0].
- R4: Internal read and write send (addr[15:8] OR (clockless_i ? 0x80 : 0x00)) and then addr[7:0]. Internal read follows with one 0x00 byte, and internal write with wdata MSB byte first.
- R5: Terminate and repeat send three 0x00 bytes after the opcode. Reset sends three 0xFF bytes.
- R6: With crc_off_i = 0, the final byte is {crc, 1'b0}. crc is the CRC7 (generator x^7+x^3+1, register preset to 0x7F, bits taken MSB first) over every earlier byte of the frame.
- R7: With crc_off_i = 1, the CRC byte is omitted and the frame is one byte shorter than in R2.
- R8: A start with an opcode not listed in R2 makes err_o high for exactly the next cycle. No byte is offered and busy_o stays 0.
- R9: While tx_valid_o is 1 and tx_ready_i is 0, tx_valid_o and tx_data_o hold their values. A byte transfers on a clock edge with both high.
- R10: start_i and the request inputs are ignored while busy_o is 1, so the frame in flight is not altered.
- R11: done_o is high for exactly one cycle, the cycle after the last byte transfers, and busy_o is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 24 | Target address |
| wdata_i | input | 32 | Write word for single and internal writes |
| size_i | input | 24 | Transfer size for DMA opcodes |
| clockless_i | input | 1 | Forces bit 7 of the internal address high byte |
| crc_off_i | input | 1 | Drops the trailing CRC byte |
| tx_data_o | output | 8 | Outgoing frame byte |
| tx_valid_o | output | 1 | tx_data_o holds a byte |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| err_o | output | 1 | One-cycle unknown-opcode pulse |

## Verification
A wrong opcode decode or field order shows in the first frame for that opcode, as a wrong byte count or a wrong byte at a fixed position. A wrong CRC register value shows only at the end of the frame, in the trailing byte, so every supported opcode is run with CRC on and CRC off under irregular ready back-pressure. A stuck state machine appears as a missing or doubled done pulse, or as bytes offered after an error, within the cycles of the same request. A start raised in the middle of every frame shows whether the latched request can be overwritten.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  parameter int unsigned BYTE_W    = 8;
  parameter int unsigned ADDR_W    = 24;
  parameter int unsigned DATA_W    = 32;
  parameter int unsigned SIZE_W    = 24;
  parameter int unsigned HDR_BYTES = 8;
  parameter int unsigned CRC_W     = 7;
  parameter logic [CRC_W-1:0] CRC_POLY = 7'h09;
  parameter logic [CRC_W-1:0] CRC_INIT = 7'h7f;

  localparam int unsigned HDR_W   = HDR_BYTES * BYTE_W;
  localparam int unsigned CNT_W   = $clog2(HDR_BYTES + 1);
  localparam int unsigned BIT_W   = $clog2(BYTE_W);

  typedef enum logic [7:0] {
    OP_DMA_WR  = 8'hc1,
    OP_DMA_RD  = 8'hc2,
    OP_INT_WR  = 8'hc3,
    OP_INT_RD  = 8'hc4,
    OP_TERM    = 8'hc5,
    OP_RPT     = 8'hc6,
    OP_XDMA_WR = 8'hc7,
    OP_XDMA_RD = 8'hc8,
    OP_SGL_WR  = 8'hc9,
    OP_SGL_RD  = 8'hca,
    OP_RST     = 8'hcf
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CRUNCH,
    ST_SEND,
    ST_CRC
  } fsm_e;
endpackage

// File: rtl/spi_cmd_layout.sv
module spi_cmd_layout
  import spi_cmd_pkg::*;
(
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              clockless_i,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [CNT_W-1:0]  hdr_len_o,
  output logic              valid_o
);
  logic [7:0] int_hi;
  assign int_hi = addr_i[15:8] | {clockless_i, 7'd0};

  // header left-aligned: first byte in the top lane
  always_comb begin
    hdr_o     = '0;
    hdr_len_o = '0;
    valid_o   = 1'b1;
    unique case (opcode_i)
      OP_SGL_RD: begin
        hdr_o     = {opcode_i, addr_i, 32'd0};
        hdr_len_o = CNT_W'(4);
      end
      OP_INT_RD: begin
        hdr_o     = {opcode_i, int_hi, addr_i[7:0], 8'h00, 32'd0};
        hdr_len_o = CNT_W'(4);
      end
      OP_TERM, OP_RPT: begin
        hdr_o     = {opcode_i, 24'h000000, 32'd0};
        hdr_len_o = CNT_W'(4);
      end
      OP_RST: begin
        hdr_o     = {opcode_i, 24'hffffff, 32'd0};
        hdr_len_o = CNT_W'(4);
      end
      OP_DMA_WR, OP_DMA_RD: begin
        hdr_o     = {opcode_i, addr_i, size_i[15:0], 16'd0};
        hdr_len_o = CNT_W'(6);
      end
      OP_XDMA_WR, OP_XDMA_RD: begin
        hdr_o     = {opcode_i, addr_i, size_i, 8'd0};
        hdr_len_o = CNT_W'(7);
      end
      OP_INT_WR: begin
        hdr_o     = {opcode_i, int_hi, addr_i[7:0], wdata_i, 8'd0};
        hdr_len_o = CNT_W'(7);
      end
      OP_SGL_WR: begin
        hdr_o     = {opcode_i, addr_i, wdata_i};
        hdr_len_o = CNT_W'(8);
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_crc7_serial.sv
module spi_crc7_serial #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] POLY = 7'h09,
  parameter logic [W-1:0] INIT = 7'h7f
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb = crc_q[W-1] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (init_i) crc_q <= INIT;
    else if (en_i)   crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              clockless_i,
  input  logic              crc_off_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  fsm_e             state_q;
  logic [HDR_W-1:0] frame_q;
  logic [CNT_W-1:0] rem_q;
  logic [BIT_W-1:0] bit_q;
  logic             crc_off_q, done_q, err_q;

  logic [HDR_W-1:0] lay_hdr;
  logic [CNT_W-1:0] lay_len;
  logic             lay_valid;
  logic [CRC_W-1:0] crc;
  logic             accept, take;

  spi_cmd_layout u_layout (
    .opcode_i   (opcode_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .size_i     (size_i),
    .clockless_i(clockless_i),
    .hdr_o      (lay_hdr),
    .hdr_len_o  (lay_len),
    .valid_o    (lay_valid)
  );

  assign take   = (state_q == ST_IDLE) && start_i;
  assign accept = tx_valid_o && tx_ready_i;

  spi_crc7_serial #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(take),
    .en_i  (state_q == ST_CRUNCH),
    .bit_i (frame_q[HDR_W-1-int'(bit_q)]),
    .crc_o (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      frame_q   <= '0;
      rem_q     <= '0;
      bit_q     <= '0;
      crc_off_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (lay_valid) begin
            frame_q   <= lay_hdr;
            rem_q     <= lay_len;
            crc_off_q <= crc_off_i;
            bit_q     <= '0;
            state_q   <= ST_CRUNCH;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_CRUNCH: begin
          bit_q <= bit_q + 1'b1;
          if (bit_q == BIT_W'(BYTE_W - 1)) state_q <= ST_SEND;
        end
        ST_SEND: if (tx_ready_i) begin
          frame_q <= frame_q << BYTE_W;
          rem_q   <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            if (crc_off_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_CRC;
            end
          end else begin
            state_q <= ST_CRUNCH;
          end
        end
        ST_CRC: if (tx_ready_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid_o = (state_q == ST_SEND) || (state_q == ST_CRC);
  assign tx_data_o  = (state_q == ST_CRC) ? {crc, 1'b0} : frame_q[HDR_W-1 -: BYTE_W];
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/spi_cmd_framer_chk.sv
module spi_cmd_framer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [7:0]  tx_data_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !tx_valid_o && !busy_o && !done_o && !err_o);

  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_done_after_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(tx_valid_o && tx_ready_i) && !busy_o);

  a_r8_err_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !tx_valid_o);

  a_r8_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  a_r8_err_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(start_i && !busy_o));

  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tx_valid_o |=> busy_o);
endmodule

bind spi_cmd_framer spi_cmd_framer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .tx_data_o (tx_data_o),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/tb_spi_cmd_framer.sv
module tb_spi_cmd_framer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [23:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [23:0] size_i = '0;
  logic        clockless_i = 1'b0;
  logic        crc_off_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;
  logic        busy_o, done_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] lfsr = 8'h5b;
  logic [7:0] eb [9];
  logic [7:0] got [9];
  int         elen;
  bit         evalid;

  always #4 clk_i = ~clk_i;

  spi_cmd_framer dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // CRC by polynomial long division of the preset-adjusted message
  function automatic logic [6:0] crc_ref(input int n);
    logic [71:0] w = '0;
    int t = 8 * n + 7;
    for (int i = 0; i < n; i++) w = {w[63:0], eb[i]};
    w = w << 7;
    w[t-1 -: 7] = w[t-1 -: 7] ^ 7'h7f;
    for (int k = t - 1; k >= 7; k--)
      if (w[k]) w[k -: 8] = w[k -: 8] ^ 8'h89;
    return w[6:0];
  endfunction

  task automatic build(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                       input logic [23:0] s, input bit cl, input bit off);
    int h;
    logic [7:0] hi;
    hi = a[15:8] | (cl ? 8'h80 : 8'h00);
    evalid = 1;
    eb[0] = op;
    h = 4;
    case (op)
      8'hca: begin eb[1] = a[23:16]; eb[2] = a[15:8]; eb[3] = a[7:0]; end  // R3
      8'hc4: begin eb[1] = hi; eb[2] = a[7:0]; eb[3] = 8'h00; end          // R4
      8'hc5, 8'hc6: begin eb[1] = 8'h00; eb[2] = 8'h00; eb[3] = 8'h00; end // R5
      8'hcf: begin eb[1] = 8'hff; eb[2] = 8'hff; eb[3] = 8'hff; end        // R5
      8'hc1, 8'hc2: begin
        eb[1] = a[23:16]; eb[2] = a[15:8]; eb[3] = a[7:0];
        eb[4] = s[15:8]; eb[5] = s[7:0]; h = 6;
      end
      8'hc7, 8'hc8: begin
        eb[1] = a[23:16]; eb[2] = a[15:8]; eb[3] = a[7:0];
        eb[4] = s[23:16]; eb[5] = s[15:8]; eb[6] = s[7:0]; h = 7;
      end
      8'hc3: begin
        eb[1] = hi; eb[2] = a[7:0];
        eb[3] = d[31:24]; eb[4] = d[23:16]; eb[5] = d[15:8]; eb[6] = d[7:0]; h = 7;
      end
      8'hc9: begin
        eb[1] = a[23:16]; eb[2] = a[15:8]; eb[3] = a[7:0];
        eb[4] = d[31:24]; eb[5] = d[23:16]; eb[6] = d[15:8]; eb[7] = d[7:0]; h = 8;
      end
      default: evalid = 0;
    endcase
    if (off) elen = h;                     // R7
    else begin
      eb[h] = {crc_ref(h), 1'b0};          // R6
      elen = h + 1;
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                     input logic [23:0] s, input bit cl, input bit off);
    int n = 0;
    int cyc = 0;
    bit acc_prev = 0;
    bit hold = 0;
    logic [7:0] held = '0;
    build(op, a, d, s, cl, off);
    @(negedge clk_i);
    opcode_i = op; addr_i = a; wdata_i = d; size_i = s;
    clockless_i = cl; crc_off_i = off; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (!evalid) begin
      chk(err_o == 1'b1, "R8 err pulse", err_o, 1);
      chk(!busy_o && !tx_valid_o, "R8 nothing sent", {busy_o, tx_valid_o}, 0);
      @(negedge clk_i);
      chk(err_o == 1'b0 && !tx_valid_o, "R8 err one cycle", {err_o, tx_valid_o}, 0);
      return;
    end
    chk(err_o == 1'b0 && busy_o, "R2 accepted", {err_o, busy_o}, 1);
    forever begin
      // R11: done exactly one cycle after the final transfer
      if (done_o) begin
        chk(acc_prev && n == elen && !busy_o, "R11 done timing", n, elen);
        @(negedge clk_i);
        chk(!done_o, "R11 done single", done_o, 0);
        break;
      end
      if (n > elen || cyc > 400) begin
        chk(0, "R11 frame end", n, elen);
        break;
      end
      // R10: start mid-frame must be ignored
      if (cyc == 3) begin
        opcode_i = 8'hc5; addr_i = ~a; start_i = 1'b1;
      end else start_i = 1'b0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready_i = lfsr[0] | lfsr[2];
      #1;
      if (hold) chk(tx_valid_o && tx_data_o == held, "R9 hold", tx_data_o, held);
      hold = tx_valid_o && !tx_ready_i;
      held = tx_data_o;
      acc_prev = tx_valid_o && tx_ready_i;
      if (acc_prev && n < 9) begin
        got[n] = tx_data_o;
        n++;
      end
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    tx_ready_i = 1'b0;
    chk(n == elen, "R2/R7 length", n, elen);
    for (int i = 0; i < elen && i < n; i++) begin
      if (i == elen - 1 && !off)
        chk(got[i] == eb[i], "R6 crc byte", got[i], eb[i]);
      else
        chk(got[i] == eb[i], "R3/R4/R5 header byte", got[i], eb[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!tx_valid_o && !busy_o && !done_o && !err_o, "R1 reset",
        {tx_valid_o, busy_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!tx_valid_o && !busy_o, "R1 idle after reset", {tx_valid_o, busy_o}, 0);
    for (int op = 0; op < 256; op++)
      for (int off = 0; off < 2; off++)
        run(8'(op), {8'(op), ~8'(op), 8'(op) ^ 8'h5a}, 32'h1234_5600 | op,
            {8'h3c, 8'(op), 8'h81}, op[0], off[0]);
    // R4: clockless forcing both ways, bit 7 of address passes through
    run(8'hc4, 24'h00_1234, 32'h0, 24'h0, 1'b1, 1'b0);
    run(8'hc3, 24'h00_1234, 32'hdead_beef, 24'h0, 1'b0, 1'b0);
    run(8'hc3, 24'h00_9234, 32'h0102_0304, 24'h0, 1'b0, 1'b1);
    run(8'hc4, 24'hff_8001, 32'h0, 24'h0, 1'b1, 1'b1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule